// File: doc/BRIEF.md
# Sticky-Reduced Significand Rounder

This unit takes a wide unsigned significand and its sign and rounds it to a narrower target precision, 53 bits by default. The wide operand is read as a fixed-point field. The top `PREC` bits are the kept part and everything below them is discarded. A 2-bit control chooses one of four rounding directions. Typical producers are a multiplier or an adder whose raw result is wider than the destination format.

The unit has two pipeline stages. The first stage folds the wide operand into a short form of `PREC+2` bits: the top `PREC+1` bits are copied unchanged, and the lowest bit is the OR of every remaining bit. The second stage rounds that short form to `PREC` bits. The short form is built so that the result matches a rounding of the full-width operand in every mode.

If rounding up carries out of the kept field, the result is renormalized to a single leading one and a flag tells the exponent logic to add one. A separate flag reports that some discarded bit was nonzero. The unit does not handle exponents, special values or packing.

Top module: `sticky_rounder`

## Requirements
- R1: A valid operand sampled on `inVld` at a rising edge produces `outVld` high, with `outSign` equal to the input sign, exactly two rising edges later. `outVld` is low in every other cycle.
- R2: The `inMode` encoding is as follows. 0 selects nearest with ties to even, 1 selects toward zero, 2 selects toward plus infinity and 3 selects toward minus infinity.
- R3: In toward-zero mode, `outSig` equals the top `PREC` bits of `inSig` and `outExpInc` is 0.
- R4: In nearest mode, the kept field is incremented when the discarded part exceeds half an ulp. When the discarded part is exactly half an ulp, the kept field is incremented only if its least significant bit is 1.
- R5: In toward-plus-infinity mode, an inexact positive operand is incremented and a negative operand is truncated. Toward-minus-infinity mode does the reverse.
- R6: `outInexact` is 1 exactly when any of the low `WIDE_W-PREC` bits of `inSig` is nonzero.
- R7: When an increment carries out of a kept field of all ones, `outSig` is 1 followed by `PREC-1` zeros and `outExpInc` is 1. In every other case `outExpInc` is 0.
- R8: The rounded result equals a rounding of the full-width operand in all modes. This includes operands whose only nonzero discarded bit lies far below the guard position.
- R9: While reset is held, and until the first result arrives, `outVld`, `outSig`, `outExpInc` and `outInexact` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Operand valid |
| inSign | input | 1 | Operand sign, 1 for negative |
| inSig | input | WIDE_W | Wide unsigned significand |
| inMode | input | 2 | Rounding direction (see R2) |
| outVld | output | 1 | Result valid |
| outSign | output | 1 | Result sign |
| outSig | output | PREC | Rounded significand |
| outExpInc | output | 1 | Carry-out renormalization flag |
| outInexact | output | 1 | Discarded bits were nonzero |

## Verification
The hardest cases to reach are exact ties and near-ties. A tie has a discarded field of exactly one half ulp. A near-tie has half an ulp plus a single bit at the very bottom of the wide operand. Random operands almost never produce either one, yet they are the only cases where a wrong sticky fold changes the nearest-mode result. The stimulus therefore builds these operands directly for both kept-field parities and all four modes, together with all-ones kept fields that force the carry-out. A random stream then runs through a full-width behavioural reference.

// File: rtl/rounder_pkg.sv
package rounder_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_POS  = 2'd2,
    RND_NEG  = 2'd3
  } rndMode_e;

  typedef struct packed {
    logic load1;      // capture short form in stage 1
    logic load2;      // capture rounded result in stage 2
    logic roundNear;  // stage 2 uses guard/sticky/lsb rule
    logic roundAway;  // stage 2 increments on any inexact
  } rndStrobe_t;

endpackage

// File: rtl/rounder_ctrl.sv
module rounder_ctrl
  import rounder_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inVld,
  input  logic       inSign,
  input  logic [1:0] inMode,
  output rndStrobe_t strobe,
  output logic       outVld
);

  rndMode_e   modeIn;
  logic       s1Vld;
  logic       s1Near;
  logic       s1Away;
  logic       awayNext;

  assign modeIn = rndMode_e'(inMode);

  always_comb begin
    unique case (modeIn)
      RND_POS: awayNext = ~inSign;
      RND_NEG: awayNext = inSign;
      default: awayNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vld  <= 1'b0;
      s1Near <= 1'b0;
      s1Away <= 1'b0;
      outVld <= 1'b0;
    end else begin
      s1Vld  <= inVld;
      outVld <= s1Vld;
      if (inVld) begin
        s1Near <= (modeIn == RND_NEAR);
        s1Away <= awayNext;
      end
    end
  end

  assign strobe.load1     = inVld;
  assign strobe.load2     = s1Vld;
  assign strobe.roundNear = s1Near;
  assign strobe.roundAway = s1Away;

endmodule

// File: rtl/rounder_dp.sv
module rounder_dp
  import rounder_pkg::*;
#(
  parameter int WIDE_W = 106,
  parameter int PREC   = 53
) (
  input  logic              clk,
  input  logic              rstN,
  input  rndStrobe_t        strobe,
  input  logic              inSign,
  input  logic [WIDE_W-1:0] inSig,
  output logic              outSign,
  output logic [PREC-1:0]   outSig,
  output logic              outExpInc,
  output logic              outInexact
);

  localparam int SHORT_W = PREC + 2;
  localparam int LOW_W   = WIDE_W - PREC - 1;

  // stage 1: sticky fold to PREC+2 bits
  logic [SHORT_W-1:0] shortNext;
  logic [SHORT_W-1:0] shortQ;
  logic               signQ;

  assign shortNext = {inSig[WIDE_W-1 -: PREC+1], |inSig[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shortQ <= '0;
      signQ  <= 1'b0;
    end else if (strobe.load1) begin
      shortQ <= shortNext;
      signQ  <= inSign;
    end
  end

  // stage 2: round the short form
  logic [PREC-1:0] kept;
  logic            guardBit;
  logic            stickyBit;
  logic            lossy;
  logic            bump;
  logic [PREC:0]   sum;
  logic [PREC-1:0] sigNext;

  assign kept      = shortQ[SHORT_W-1:2];
  assign guardBit  = shortQ[1];
  assign stickyBit = shortQ[0];
  assign lossy     = guardBit | stickyBit;

  always_comb begin
    if (strobe.roundNear) bump = guardBit & (stickyBit | kept[0]);
    else                  bump = strobe.roundAway & lossy;
    sum = {1'b0, kept} + {{PREC{1'b0}}, bump};
    if (sum[PREC]) sigNext = {1'b1, {(PREC-1){1'b0}}};
    else           sigNext = sum[PREC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSign    <= 1'b0;
      outSig     <= '0;
      outExpInc  <= 1'b0;
      outInexact <= 1'b0;
    end else if (strobe.load2) begin
      outSign    <= signQ;
      outSig     <= sigNext;
      outExpInc  <= sum[PREC];
      outInexact <= lossy;
    end
  end

endmodule

// File: rtl/sticky_rounder.sv
module sticky_rounder
  import rounder_pkg::*;
#(
  parameter int WIDE_W = 106,
  parameter int PREC   = 53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  input  logic              inSign,
  input  logic [WIDE_W-1:0] inSig,
  input  logic [1:0]        inMode,
  output logic              outVld,
  output logic              outSign,
  output logic [PREC-1:0]   outSig,
  output logic              outExpInc,
  output logic              outInexact
);

  rndStrobe_t strobe;

  rounder_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .inSign (inSign),
    .inMode (inMode),
    .strobe (strobe),
    .outVld (outVld)
  );

  rounder_dp #(.WIDE_W(WIDE_W), .PREC(PREC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inSign     (inSign),
    .inSig      (inSig),
    .outSign    (outSign),
    .outSig     (outSig),
    .outExpInc  (outExpInc),
    .outInexact (outInexact)
  );

endmodule

// File: rtl/sticky_rounder_chk.sv
module sticky_rounder_chk #(
  parameter int PREC = 53
) (
  input logic            clk,
  input logic            rstN,
  input logic            inVld,
  input logic            inSign,
  input logic [1:0]      inMode,
  input logic            outVld,
  input logic            outSign,
  input logic [PREC-1:0] outSig,
  input logic            outExpInc,
  input logic            outInexact
);

  // R1
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inVld, 2) == outVld);

  // R1
  sign_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> outSign == $past(inSign, 2));

  // R3
  zero_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && $past(inMode, 2) == 2'd1) |-> !outExpInc);

  // R7
  carry_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    outExpInc |-> (outSig == {1'b1, {(PREC-1){1'b0}}} && outInexact));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!outVld && outSig == '0 && !outExpInc && !outInexact));

endmodule

bind sticky_rounder sticky_rounder_chk #(.PREC(PREC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inVld      (inVld),
  .inSign     (inSign),
  .inMode     (inMode),
  .outVld     (outVld),
  .outSign    (outSign),
  .outSig     (outSig),
  .outExpInc  (outExpInc),
  .outInexact (outInexact)
);

// File: tb/sim_sticky_rounder.sv
module sim_sticky_rounder;

  localparam int W = 106;
  localparam int P = 53;
  localparam int L = W - P;

  typedef struct packed {
    logic         sign;
    logic [P-1:0] sig;
    logic         inc;
    logic         inexact;
    logic [1:0]   mode;
  } expect_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inVld = 1'b0;
  logic         inSign = 1'b0;
  logic [W-1:0] inSig = '0;
  logic [1:0]   inMode = 2'd0;
  logic         outVld;
  logic         outSign;
  logic [P-1:0] outSig;
  logic         outExpInc;
  logic         outInexact;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  expect_t expQ[$];
  logic    d1 = 1'b0;
  logic    expVld = 1'b0;

  always #5 clk = ~clk;

  sticky_rounder #(.WIDE_W(W), .PREC(P)) u0 (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inSign(inSign), .inSig(inSig),
    .inMode(inMode), .outVld(outVld), .outSign(outSign), .outSig(outSig),
    .outExpInc(outExpInc), .outInexact(outInexact)
  );

  function automatic expect_t refRound(logic [W-1:0] sig, logic sign, logic [1:0] mode);
    expect_t      e;
    logic [P-1:0] kept;
    logic [L-1:0] rem;
    logic [L-1:0] half;
    logic         up;
    logic [P:0]   sum;
    kept = sig[W-1:L];
    rem  = sig[L-1:0];
    half = {1'b1, {(L-1){1'b0}}};
    e.inexact = (rem != '0);
    case (mode)
      2'd0: up = (rem > half) || (rem == half && kept[0]);
      2'd1: up = 1'b0;
      2'd2: up = !sign && e.inexact;
      default: up = sign && e.inexact;
    endcase
    sum = {1'b0, kept} + (up ? 1 : 0);
    e.inc  = sum[P];
    e.sig  = sum[P] ? {1'b1, {(P-1){1'b0}}} : sum[P-1:0];
    e.sign = sign;
    e.mode = mode;
    return e;
  endfunction

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'd0: return "R2/R4/R8";
      2'd1: return "R2/R3/R8";
      default: return "R2/R5/R8";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [P-1:0] act, logic [P-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      cycles <= cycles + 1;
      expVld <= d1;
      d1     <= inVld;
      if (inVld) expQ.push_back(refRound(inSig, inSign, inMode));
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(outVld === expVld, "R1", "valid", P'(outVld), P'(expVld));
      if (expVld && expQ.size() > 0) begin
        expect_t e;
        e = expQ.pop_front();
        chk(outSig === e.sig, modeTag(e.mode), "sig", outSig, e.sig);
        chk(outSign === e.sign, "R1", "sign", P'(outSign), P'(e.sign));
        chk(outInexact === e.inexact, "R6", "inexact", P'(outInexact), P'(e.inexact));
        chk(outExpInc === e.inc, "R7", "expinc", P'(outExpInc), P'(e.inc));
      end
    end
  end

  task automatic send(logic [W-1:0] s, logic sg, logic [1:0] m);
    @(negedge clk);
    inVld = 1'b1; inSig = s; inSign = sg; inMode = m;
  endtask

  task automatic idle();
    @(negedge clk);
    inVld = 1'b0; inSig = {W{1'b1}};
  endtask

  function automatic logic [W-1:0] rnd106();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    return r[W-1:0];
  endfunction

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [W-1:0] half;
    logic [W-1:0] evenK;
    logic [W-1:0] oddK;
    half  = {{P{1'b0}}, 1'b1, {(L-1){1'b0}}};
    evenK = {1'b1, {(P-2){1'b0}}, 1'b0, {L{1'b0}}};
    oddK  = {1'b1, {(P-2){1'b0}}, 1'b1, {L{1'b0}}};
    repeat (3) @(negedge clk);
    // R9: idle outputs during reset
    chk(outVld === 1'b0 && outSig === '0 && outExpInc === 1'b0 && outInexact === 1'b0,
        "R9", "reset state", outSig, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outVld === 1'b0 && outSig === '0, "R9", "after reset", outSig, '0);
    for (int m = 0; m < 4; m++) begin
      for (int sg = 0; sg < 2; sg++) begin
        send(evenK, sg[0], m[1:0]);                              // exact
        send(evenK | half, sg[0], m[1:0]);                       // tie, even kept (R4)
        send(oddK | half, sg[0], m[1:0]);                        // tie, odd kept (R4)
        send(evenK | half | 1, sg[0], m[1:0]);                   // near tie, deep bit (R8)
        send(evenK | (half - 1), sg[0], m[1:0]);                 // just below half
        send(evenK | 1, sg[0], m[1:0]);                          // only deepest bit (R6/R8)
        send({{P{1'b1}}, {L{1'b0}}} | half, sg[0], m[1:0]);      // carry on tie (R7)
        send({{P{1'b1}}, {(L-1){1'b0}}, 1'b1}, sg[0], m[1:0]);   // carry via sticky (R7)
        send({W{1'b1}}, sg[0], m[1:0]);                          // all ones
        idle();
      end
    end
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] s;
      s = rnd106();
      if (i % 5 == 0) s[L-1:0] = half[L-1:0];
      if (i % 7 == 0) s[L-1:0] = '0;
      send(s, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)));
      if (i % 9 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

endmodule